// File: doc/BRIEF.md
# Binary to Residue Forward Converter

This block turns a 32-bit two's complement word into a residue tuple over two pairwise coprime moduli: an odd channel of modulus 2^n−1 and an even channel of modulus 2^k. The odd channel adds up the n-bit slices of the word. A bit at position i+n·j has the same weight modulo 2^n−1 as a bit at position i, so every slice lands on the same columns. The slices pass through a carry-save tree whose carries wrap end-around. A single closing adder with end-around carry then resolves the result. The even channel needs no arithmetic, because its residue is the low k bits of the word.

Each conversion is issued as its own operation with a valid strobe. The result comes out exactly one clock later, and there is no backpressure. A negative input is mapped into the dynamic range M = (2^n−1)·2^k before reduction. Both residues are therefore the non-negative remainders of the signed value. With the default n=11 and k=22, the tuple packs into 33 bits.

Top module: `rns_fwd_conv`

## Requirements
- R1: When a conversion is issued, the odd-channel residue equals the signed input value modulo 2^n−1 (default 2047), taken as a non-negative remainder.
- R2: The even-channel residue equals the low k bits (default 22) of the input word.
- R3: The packed output carries the odd-channel residue in bits [n+k−1:k] (default [32:22]) and the even-channel residue in bits [k−1:0] (default [21:0]).
- R4: The odd-channel residue is never all ones. A folded sum equal to 2^n−1 is normalised to zero.
- R5: The output valid strobe rises exactly one clock after an input valid, and it is low in the cycle after a clock with no input valid.
- R6: In a cycle without an input valid, the residue output keeps its previous value.
- R7: During reset and after it, the output valid is low and the residue output is zero until the first conversion.
- R8: A negative input is reduced as the input plus M = (2^n−1)·2^k. For example, −1 yields an odd-channel residue of 2046 and an even-channel residue of all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inVld | input | 1 | Issues a conversion of inWord |
| inWord | input | 32 | Two's complement operand |
| outVld | output | 1 | Result valid, one clock after inVld |
| outRes | output | 33 | Packed residue tuple: odd channel high, even channel low |

## Verification
On every cycle the assertions check the following:
- the one-clock valid latency;
- that neither residue ever differs from a behavioural modulo of the issued word;
- that the all-ones code never appears;
- that the output holds while idle.

The bench scenarios are needed to show other behaviour. These are the exact residues at the corner inputs: zero, −1, the most positive and most negative words, multiples of 2047, and 2^22−1, which folds to all ones. The scenarios also show back-to-back issue and the value at reset.

// File: rtl/rns_fwd_pkg.sv
package rns_fwd_pkg;
  typedef struct packed {
    logic load;
    logic clear;
  } cvtCtrl_t;
endpackage

// File: rtl/rns_fwd_ctrl.sv
module rns_fwd_ctrl
  import rns_fwd_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     inVld,
  output cvtCtrl_t ctrl,
  output logic     outVld
);
  always_comb begin
    ctrl.load  = inVld;
    ctrl.clear = !rstN;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outVld <= 1'b0;
    else       outVld <= inVld;
  end

  // R5: the strobe follows the issue by exactly one clock
  a_r5_latency: assert property (@(posedge clk) disable iff (!rstN)
    inVld |=> outVld);
  a_r5_idle: assert property (@(posedge clk) disable iff (!rstN)
    !inVld |=> !outVld);
endmodule

// File: rtl/rns_fwd_dp.sv
module rns_fwd_dp
  import rns_fwd_pkg::*;
#(
  parameter int W = 32,
  parameter int N = 11,
  parameter int K = 22
) (
  input  logic           clk,
  input  cvtCtrl_t       ctrl,
  input  logic [W-1:0]   inWord,
  output logic [N+K-1:0] outRes
);
  localparam int SL   = (W + N - 1) / N;   // slices folded onto n columns
  localparam int OPS  = SL + 1;            // plus sign correction operand
  localparam int PADW = SL * N;
  localparam int REM  = W % N;             // 2^W mod (2^N-1) = 2^REM
  localparam logic [N-1:0] ALLONES = {N{1'b1}};
  localparam logic [N-1:0] CORR    = ALLONES - N'(1 << REM);

  logic [PADW-1:0] padWord;
  logic [N-1:0]    opnd [OPS];
  logic [N-1:0]    sumV [OPS-1];
  logic [N-1:0]    carV [OPS-1];
  logic [N:0]      finSum;
  logic [N-1:0]    wrapSum;
  logic [N-1:0]    oddRes;

  assign padWord = PADW'(inWord);

  genvar gi;
  generate
    for (gi = 0; gi < SL; gi++) begin : gSlice
      assign opnd[gi] = padWord[gi*N +: N];
    end
  endgenerate

  // a negative word stands for value+2^W; adding CORR subtracts 2^W mod (2^N-1)
  assign opnd[SL] = inWord[W-1] ? CORR : '0;

  assign sumV[0] = opnd[0];
  assign carV[0] = opnd[1];
  generate
    for (gi = 2; gi < OPS; gi++) begin : gCsa
      logic [N-1:0] maj;
      assign sumV[gi-1] = sumV[gi-2] ^ carV[gi-2] ^ opnd[gi];
      assign maj        = (sumV[gi-2] & carV[gi-2]) | (sumV[gi-2] & opnd[gi]) |
                          (carV[gi-2] & opnd[gi]);
      assign carV[gi-1] = {maj[N-2:0], maj[N-1]};   // end-around carry
    end
  endgenerate

  always_comb begin
    finSum  = {1'b0, sumV[OPS-2]} + {1'b0, carV[OPS-2]};
    wrapSum = finSum[N-1:0] + N'(finSum[N]);
    oddRes  = (wrapSum == ALLONES) ? '0 : wrapSum;
  end

  always_ff @(posedge clk) begin
    if (ctrl.clear)     outRes <= '0;
    else if (ctrl.load) outRes <= {oddRes, inWord[K-1:0]};
  end

  // R4: the all-ones code of the odd channel never leaves the block
  a_r4_norm: assert property (@(posedge clk) disable iff (ctrl.clear)
    outRes[N+K-1:K] != ALLONES);
  // R6: no load, no change
  a_r6_hold: assert property (@(posedge clk) disable iff (ctrl.clear)
    !ctrl.load |=> $stable(outRes));
endmodule

// File: rtl/rns_fwd_conv.sv
module rns_fwd_conv
  import rns_fwd_pkg::*;
#(
  parameter int W = 32,
  parameter int N = 11,
  parameter int K = 22
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           inVld,
  input  logic [W-1:0]   inWord,
  output logic           outVld,
  output logic [N+K-1:0] outRes
);
  localparam longint MODV = (longint'(1) << N) - 1;

  cvtCtrl_t ctrl;

  rns_fwd_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .inVld(inVld), .ctrl(ctrl), .outVld(outVld)
  );

  rns_fwd_dp #(.W(W), .N(N), .K(K)) uDp (
    .clk(clk), .ctrl(ctrl), .inWord(inWord), .outRes(outRes)
  );

  function automatic longint refMod(input logic [W-1:0] w);
    longint v, r;
    v = longint'(signed'(w));
    r = v % MODV;
    if (r < 0) r = r + MODV;
    return r;
  endfunction

  // R1, R8: odd channel matches a behavioural signed modulo
  a_r1_mod: assert property (@(posedge clk) disable iff (!rstN)
    inVld |=> longint'(outRes[N+K-1:K]) == refMod($past(inWord)));
  // R2, R3: even channel sits in the low field
  a_r2_low: assert property (@(posedge clk) disable iff (!rstN)
    inVld |=> outRes[K-1:0] == $past(inWord[K-1:0]));
endmodule

// File: tb/tb_rns_fwd_conv.sv
module tb_rns_fwd_conv;
  localparam int NV = 12;
  localparam logic [31:0] VIN [NV] = '{
    32'd0, 32'hFFFF_FFFF, 32'd2047, 32'd4094, 32'd2046, 32'd1,
    32'h7FFF_FFFF, 32'h8000_0000, 32'd2047000, 32'h003F_FFFF,
    32'hFFFF_F801, 32'd12345 };
  localparam logic [10:0] VODD [NV] = '{
    11'd0, 11'd2046, 11'd0, 11'd0, 11'd2046, 11'd1,
    11'd511, 11'd1535, 11'd0, 11'd0, 11'd0, 11'd63 };

  logic clk = 0, rstN = 0, inVld = 0;
  logic [31:0] inWord = '0;
  logic outVld;
  logic [32:0] outRes;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rns_fwd_conv dut (.clk(clk), .rstN(rstN), .inVld(inVld), .inWord(inWord),
                    .outVld(outVld), .outRes(outRes));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] w);
    inVld = 1; inWord = w;
    @(negedge clk);
    inVld = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R7 reset valid", 64'(outVld), 0);
    chk("R7 reset data", 64'(outRes), 0);
    rstN = 1;
    @(negedge clk);
    chk("R7 idle after reset", 64'(outRes), 0);

    for (int i = 0; i < NV; i++) begin
      issue(VIN[i]);
      chk("R5 valid", 64'(outVld), 1);
      chk("R1 R8 odd residue", 64'(outRes[32:22]), 64'(VODD[i]));
      chk("R2 R3 low residue", 64'(outRes[21:0]), 64'(VIN[i][21:0]));
      chk("R4 not all ones", 64'(outRes[32:22] == 11'h7FF), 0);
    end

    // hold: idle cycle after last result
    @(negedge clk);
    chk("R5 valid drops", 64'(outVld), 0);
    chk("R6 held", 64'(outRes), {VODD[NV-1], VIN[NV-1][21:0]});

    // back-to-back issue
    inVld = 1; inWord = 32'd2048;
    @(negedge clk);
    chk("R1 b2b first", 64'(outRes[32:22]), 1);
    inWord = 32'hFFFF_FFFE;
    @(negedge clk);
    inVld = 0;
    chk("R8 b2b neg", 64'(outRes[32:22]), 2045);
    chk("R2 b2b low", 64'(outRes[21:0]), 64'(22'h3FFFFE));
    chk("R5 b2b valid", 64'(outVld), 1);

    // reset clears a loaded result
    rstN = 0;
    @(negedge clk);
    chk("R7 reset clears", 64'(outRes), 0);
    chk("R7 reset valid low", 64'(outVld), 0);
    done = 1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(negedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule